// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is an eight-pin general purpose I/O port controlled through a flat register interface with a one-cycle write strobe and a combinational read path. Each pin carries its own configuration: whether it drives or listens, whether its value is inverted between the register and the pad, which input condition raises a flag, how the output stage drives the pad, and which pull setting is requested. The pull setting is only forwarded to the pad ring on a configuration output. The block does not model pull resistors.

Software changes direction and output values either with a plain write or with atomic set, clear and toggle aliases, so one pin can change without a read-modify-write. A separate pin-select register picks which pins a configuration write lands on, so a group of pins can be set up in one access. Pad inputs pass through a two-flop synchronizer. Edge or level detection then sets sticky per-pin flags, raises a one-cycle event pulse per pin, and drives a single masked port interrupt.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset the direction, output, configuration, pin-select, interrupt-mask and flag registers read 0, `pad_oe` is 0 and `irq` is 0.
- R2: Address 0 writes the direction register outright. Addresses 1, 2 and 3 set, clear and toggle the direction bits where the written bit is 1, and leave bits written 0 unchanged.
- R3: Address 4 writes the output register outright. Addresses 5, 6 and 7 set, clear and toggle the output bits where the written bit is 1, and leave bits written 0 unchanged.
- R4: Reading address 0 or 4 returns the stored direction or output register, whatever the pad input carries.
- R5: A pin whose direction bit is 0 never drives (`pad_oe` 0). In totem-pole mode a pin with direction bit 1 drives `pad_o` = output bit XOR its inversion bit.
- R6: In wired-AND mode (drive field 1) a pin drives 0 only when its inverted output value is 0 and is released otherwise. In wired-OR mode (drive field 2) it drives 1 only when that value is 1 and is released otherwise. Drive field 0 and 3 mean totem-pole.
- R7: Reading address 8 returns the pad input after a two-cycle synchronizer, XORed with each pin's inversion bit.
- R8: Sense field values 0, 1 and 2 flag both edges, rising edges only and falling edges only of the inverted, synchronized input. A detected condition sets the pin's flag one cycle after the synchronized value changes.
- R9: Sense field value 3 (low level) sets the pin's flag on every cycle the inverted input is low, so a clear written while the level persists leaves the flag set.
- R10: Flags at address 11 are sticky and cleared by writing 1. `irq` is the OR of flags ANDed with the mask at address 12. `evt` pulses for each cycle a pin's condition is detected, in step with its flag being set.
- R11: Writing address 10 loads the 8-bit configuration byte (bit 0 inversion, bits 2:1 sense, bits 4:3 drive, bits 6:5 pull, where pull is 0 none, 1 down, 2 up and 3 keeper) into every pin selected by the mask at address 9, and no other pin. Reading address 10 returns the configuration of the lowest selected pin. `pull_cfg[2i+1:2i]` reports pin i's pull field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 8 | Combinational read data |
| pad_i | input | 8 | Pad input values |
| pad_o | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pull_cfg | output | 16 | Per-pin pull setting, two bits per pin |
| evt | output | 8 | Per-pin detection event pulse |
| irq | output | 1 | Masked port interrupt |

## Verification
The assertions check several rules on every cycle:
- The set alias on direction and the clear alias on output.
- The output register holds when no output address is written.
- No pin drives while its direction bit is 0.
- Every event pulse coincides with its flag being set.
- Flags never drop without a clear write.

Only the bench scenarios can show the timing and selection behaviours. These include the two-cycle synchronizer latency, the choice between edge and level sensing, and the wired-AND and wired-OR release patterns. They also include masked configuration landing on the selected pins only, and a low-level flag surviving its own clear.

// File: rtl/gpio_pkg.sv
// Shared types for the GPIO port controller: register addresses and the
// per-pin configuration byte. Assumes a 4-bit register address space.
package gpio_pkg;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned CFG_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR     = 4'd0,
        A_DIR_SET = 4'd1,
        A_DIR_CLR = 4'd2,
        A_DIR_TGL = 4'd3,
        A_OUT     = 4'd4,
        A_OUT_SET = 4'd5,
        A_OUT_CLR = 4'd6,
        A_OUT_TGL = 4'd7,
        A_IN      = 4'd8,
        A_SEL     = 4'd9,
        A_CFG     = 4'd10,
        A_FLAG    = 4'd11,
        A_IMASK   = 4'd12
    } addr_e;

    typedef enum logic [1:0] {SNS_BOTH, SNS_RISE, SNS_FALL, SNS_LOW} sense_e;
    typedef enum logic [1:0] {DRV_TOTEM, DRV_WAND, DRV_WOR, DRV_TOTEM_ALT} drive_e;
    typedef enum logic [1:0] {PULL_NONE, PULL_DOWN, PULL_UP, PULL_KEEP} pull_e;

    typedef struct packed {
        logic   rsvd;
        pull_e  pull;
        drive_e drive;
        sense_e sense;
        logic   inv;
    } pin_cfg_t;
endpackage

// File: rtl/gpio_regs.sv
// Register file of the port: direction and output registers with
// write/set/clear/toggle aliases, masked per-pin configuration, pin-select
// and interrupt-mask registers, and the write-one-to-clear strobe for flags.
// Assumes NPINS >= CFG_W so the configuration byte fits in the data word.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [NPINS-1:0]      wr_data,
    output logic [NPINS-1:0]      dir_q,
    output logic [NPINS-1:0]      out_q,
    output logic [NPINS-1:0]      sel_q,
    output logic [NPINS-1:0]      imask_q,
    output logic [NPINS-1:0]      flag_clr,
    output pin_cfg_t [NPINS-1:0]  cfg_q
);
    logic       hit_dir, hit_out;
    logic [1:0] op;

    // Applies one of the four alias operations to a register value.
    function automatic logic [NPINS-1:0] alias_upd(input logic [NPINS-1:0] cur,
                                                   input logic [NPINS-1:0] d,
                                                   input logic [1:0]       kind);
        case (kind)
            2'd0:    return d;
            2'd1:    return cur | d;
            2'd2:    return cur & ~d;
            default: return cur ^ d;
        endcase
    endfunction

    assign op       = wr_addr[1:0];
    assign hit_dir  = wr_en && (wr_addr[3:2] == 2'b00);
    assign hit_out  = wr_en && (wr_addr[3:2] == 2'b01);
    assign flag_clr = (wr_en && wr_addr == A_FLAG) ? wr_data : '0;

    // Direction and output registers with their alias decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (hit_dir) dir_q <= alias_upd(dir_q, wr_data, op);
            if (hit_out) out_q <= alias_upd(out_q, wr_data, op);
        end
    end

    // Pin-select and interrupt-mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            imask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_SEL)   sel_q   <= wr_data;
            if (wr_addr == A_IMASK) imask_q <= wr_data;
        end
    end

    // Configuration byte lands on every selected pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && wr_addr == A_CFG) begin
            for (int i = 0; i < NPINS; i++) begin
                if (sel_q[i]) cfg_q[i] <= pin_cfg_t'(wr_data[CFG_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/gpio_sense.sv
// Input path: synchronizer chain, per-pin inversion, edge/level detection
// and sticky flags. Assumes SYNC_STAGES >= 2. A set from detection wins over
// a clear in the same cycle, so a persisting low level keeps its flag.
module gpio_sense
    import gpio_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     pad_i,
    input  logic [NPINS-1:0]     inv,
    input  sense_e [NPINS-1:0]   sense,
    input  logic [NPINS-1:0]     flag_clr,
    output logic [NPINS-1:0]     in_val,
    output logic [NPINS-1:0]     flag_q,
    output logic [NPINS-1:0]     evt_q
);
    logic [NPINS-1:0] sync_q [SYNC_STAGES];
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] det;

    // Synchronizer chain from the pads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= pad_i;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    assign in_val = sync_q[SYNC_STAGES-1] ^ inv;

    // Per-pin detection of the selected condition.
    for (genvar i = 0; i < NPINS; i++) begin : g_det
        assign det[i] = (sense[i] == SNS_BOTH) ? (in_val[i] ^ prev_q[i]) :
                        (sense[i] == SNS_RISE) ? (in_val[i] & ~prev_q[i]) :
                        (sense[i] == SNS_FALL) ? (~in_val[i] & prev_q[i]) :
                                                 ~in_val[i];
    end

    // Previous-value, sticky flag and event pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
            evt_q  <= '0;
        end else begin
            prev_q <= in_val;
            flag_q <= (flag_q & ~flag_clr) | det;
            evt_q  <= det;
        end
    end
endmodule

// File: rtl/gpio_pad_drive.sv
// Output path: per-pin inversion and drive mode to pad value and enable.
// Open-drain style modes are emulated by releasing the enable. Assumes an
// external pad ring resolves released pins.
module gpio_pad_drive
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0]    dir,
    input  logic [NPINS-1:0]    out,
    input  logic [NPINS-1:0]    inv,
    input  drive_e [NPINS-1:0]  drive,
    output logic [NPINS-1:0]    pad_o,
    output logic [NPINS-1:0]    pad_oe
);
    logic [NPINS-1:0] val;

    assign val = out ^ inv;

    // Per-pin drive stage selection.
    for (genvar i = 0; i < NPINS; i++) begin : g_drv
        assign pad_o[i]  = (drive[i] == DRV_WAND) ? 1'b0 :
                           (drive[i] == DRV_WOR)  ? 1'b1 : val[i];
        assign pad_oe[i] = dir[i] & ((drive[i] == DRV_WAND) ? ~val[i] :
                                     (drive[i] == DRV_WOR)  ?  val[i] : 1'b1);
    end
endmodule

// File: rtl/gpio_port_ctl.sv
// Top of the GPIO port controller: ties register file, input sensing and
// pad drive together, builds the read mux and the masked interrupt.
// Assumes NPINS >= 8 (configuration byte readback) and a synchronous reset.
module gpio_port_ctl
    import gpio_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           wr_addr,
    input  logic [NPINS-1:0]     wr_data,
    input  logic [3:0]           rd_addr,
    output logic [NPINS-1:0]     rd_data,
    input  logic [NPINS-1:0]     pad_i,
    output logic [NPINS-1:0]     pad_o,
    output logic [NPINS-1:0]     pad_oe,
    output logic [2*NPINS-1:0]   pull_cfg,
    output logic [NPINS-1:0]     evt,
    output logic                 irq
);
    logic [NPINS-1:0]     dir_q, out_q, sel_q, imask_q, flag_clr, flag_q, in_val, inv_vec;
    pin_cfg_t [NPINS-1:0] cfg_q;
    sense_e   [NPINS-1:0] sense_vec;
    drive_e   [NPINS-1:0] drive_vec;
    pin_cfg_t             cfg_rd;

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dir_q(dir_q), .out_q(out_q), .sel_q(sel_q), .imask_q(imask_q),
        .flag_clr(flag_clr), .cfg_q(cfg_q)
    );

    // Split the per-pin configuration into the fields each path needs.
    for (genvar i = 0; i < NPINS; i++) begin : g_split
        assign inv_vec[i]        = cfg_q[i].inv;
        assign sense_vec[i]      = cfg_q[i].sense;
        assign drive_vec[i]      = cfg_q[i].drive;
        assign pull_cfg[2*i +: 2] = cfg_q[i].pull;
    end

    gpio_sense #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .inv(inv_vec), .sense(sense_vec),
        .flag_clr(flag_clr), .in_val(in_val), .flag_q(flag_q), .evt_q(evt)
    );

    gpio_pad_drive #(.NPINS(NPINS)) u_drive (
        .dir(dir_q), .out(out_q), .inv(inv_vec), .drive(drive_vec),
        .pad_o(pad_o), .pad_oe(pad_oe)
    );

    assign irq = |(flag_q & imask_q);

    // Configuration readback from the lowest selected pin.
    always_comb begin
        cfg_rd = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (sel_q[i]) cfg_rd = cfg_q[i];
        end
    end

    // Register read mux.
    always_comb begin
        case (rd_addr)
            A_DIR:   rd_data = dir_q;
            A_OUT:   rd_data = out_q;
            A_IN:    rd_data = in_val;
            A_SEL:   rd_data = sel_q;
            A_CFG:   rd_data = NPINS'(cfg_rd);
            A_FLAG:  rd_data = flag_q;
            A_IMASK: rd_data = imask_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_ctl_chk.sv
// Checker for the GPIO port controller, bound to the top. Watches register
// alias updates, output-enable safety and flag/event consistency.
module gpio_port_ctl_chk
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       wr_addr,
    input logic [NPINS-1:0] wr_data,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] out_q,
    input logic [NPINS-1:0] flag_q,
    input logic [NPINS-1:0] evt,
    input logic [NPINS-1:0] pad_oe
);
    a_r2_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIR_SET) |=> (dir_q == ($past(dir_q) | $past(wr_data))));

    a_r3_out_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OUT_CLR) |=> (out_q == ($past(out_q) & ~$past(wr_data))));

    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr[3:2] == 2'b01) |=> $stable(out_q));

    a_r5_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~dir_q) == '0));

    a_r10_evt_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & ~flag_q) == '0));

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dir_q(dir_q), .out_q(out_q), .flag_q(flag_q), .evt(evt), .pad_oe(pad_oe)
);

// File: tb/tb_gpio_port_ctl.sv
// Directed bench for the GPIO port controller: one task per scenario.
module tb_gpio_port_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  pad_i = '0;
    logic [7:0]  pad_o, pad_oe, evt;
    logic [15:0] pull_cfg;
    logic        irq;
    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pad_i(pad_i), .pad_o(pad_o),
        .pad_oe(pad_oe), .pull_cfg(pull_cfg), .evt(evt), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(input logic [7:0] v);
        @(negedge clk);
        pad_i = v;
        cyc(4);
        wr(4'd11, 8'hFF);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(4'd0, d);  chk("R1 dir", d, 8'h00);
        rd(4'd4, d);  chk("R1 out", d, 8'h00);
        rd(4'd11, d); chk("R1 flags", d, 8'h00);
        rd(4'd12, d); chk("R1 imask", d, 8'h00);
        rd(4'd10, d); chk("R1 cfg", d, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_dir_alias();
        logic [7:0] d;
        wr(4'd0, 8'hA5); rd(4'd0, d); chk("R2 dir write", d, 8'hA5);
        wr(4'd1, 8'h0F); rd(4'd0, d); chk("R2 dir set", d, 8'hAF);
        wr(4'd2, 8'h81); rd(4'd0, d); chk("R2 dir clr", d, 8'h2E);
        wr(4'd3, 8'hFF); rd(4'd0, d); chk("R2 dir tgl", d, 8'hD1);
        chk("R5 oe follows dir", pad_oe, 8'hD1);
    endtask

    task automatic t_out_alias();
        logic [7:0] d;
        wr(4'd0, 8'hFF);
        wr(4'd4, 8'h3C); rd(4'd4, d); chk("R3 out write", d, 8'h3C);
        wr(4'd5, 8'h01); rd(4'd4, d); chk("R3 out set", d, 8'h3D);
        wr(4'd6, 8'h30); rd(4'd4, d); chk("R3 out clr", d, 8'h0D);
        wr(4'd7, 8'h0F); rd(4'd4, d); chk("R3 out tgl", d, 8'h02);
        chk("R5 totem pad_o", pad_o, 8'h02);
        chk("R5 totem pad_oe", pad_oe, 8'hFF);
        wr(4'd0, 8'h00);
        chk("R5 input released", pad_oe, 8'h00);
        pad_i = 8'hFF;
        cyc(3);
        rd(4'd4, d); chk("R4 out stored", d, 8'h02);
        rd(4'd0, d); chk("R4 dir stored", d, 8'h00);
    endtask

    task automatic t_cfg_mask();
        logic [7:0] d;
        wr(4'd9, 8'h0C); wr(4'd10, 8'h01);
        wr(4'd9, 8'h04); rd(4'd10, d); chk("R11 selected pin cfg", d, 8'h01);
        wr(4'd9, 8'h01); rd(4'd10, d); chk("R11 unselected pin cfg", d, 8'h00);
        wr(4'd0, 8'hFF); wr(4'd4, 8'h00);
        chk("R5 output inversion", pad_o, 8'h0C);
        wr(4'd9, 8'h80); wr(4'd10, 8'h40);
        chk("R11 pull report", pull_cfg, 16'h8000);
        wr(4'd9, 8'hFF); wr(4'd10, 8'h00);
    endtask

    task automatic t_wired();
        wr(4'd9, 8'h0F); wr(4'd10, 8'h08);
        wr(4'd9, 8'hF0); wr(4'd10, 8'h10);
        wr(4'd4, 8'h5A);
        chk("R6 wired oe", pad_oe, 8'h55);
        chk("R6 wired value", pad_o, 8'hF0);
        wr(4'd9, 8'h01); wr(4'd10, 8'h09);
        chk("R6 wired-and inverted", pad_oe, 8'h54);
        wr(4'd9, 8'hFF); wr(4'd10, 8'h00);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_input();
        logic [7:0] d;
        settle(8'h00);
        @(negedge clk); pad_i = 8'h96;
        cyc(1); rd(4'd8, d); chk("R7 sync latency", d, 8'h00);
        cyc(1); rd(4'd8, d); chk("R7 sync value", d, 8'h96);
        wr(4'd9, 8'h01); wr(4'd10, 8'h01);
        rd(4'd8, d); chk("R7 input inversion", d, 8'h97);
        wr(4'd10, 8'h00); wr(4'd9, 8'h00);
    endtask

    task automatic t_edges();
        logic [7:0] d;
        wr(4'd9, 8'h02); wr(4'd10, 8'h02);
        wr(4'd9, 8'h04); wr(4'd10, 8'h04);
        wr(4'd9, 8'h00);
        settle(8'h00);
        @(negedge clk); pad_i = 8'h07;
        cyc(3); chk("R10 evt pulse", evt, 8'h03);
        cyc(1); chk("R10 evt one cycle", evt, 8'h00);
        rd(4'd11, d); chk("R8 rising flags", d, 8'h03);
        wr(4'd11, 8'hFF);
        @(negedge clk); pad_i = 8'h00;
        cyc(4);
        rd(4'd11, d); chk("R8 falling flags", d, 8'h05);
        wr(4'd11, 8'hFF);
    endtask

    task automatic t_low();
        logic [7:0] d;
        wr(4'd9, 8'h08); wr(4'd10, 8'h06); wr(4'd9, 8'h00);
        settle(8'h08);
        rd(4'd11, d); chk("R9 high no flag", d, 8'h00);
        @(negedge clk); pad_i = 8'h00;
        cyc(4);
        rd(4'd11, d); chk("R9 low flag", d, 8'h08);
        wr(4'd11, 8'h08);
        rd(4'd11, d); chk("R9 clear while low", d, 8'h08);
        chk("R10 evt during low", evt, 8'h08);
        settle(8'h08);
        rd(4'd11, d); chk("R9 cleared after high", d, 8'h00);
        wr(4'd9, 8'h08); wr(4'd10, 8'h00); wr(4'd9, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        settle(8'h00);
        @(negedge clk); pad_i = 8'h01;
        cyc(4);
        rd(4'd11, d); chk("R10 flag set", d, 8'h01);
        chk("R10 irq masked", irq, 1'b0);
        wr(4'd12, 8'h01); chk("R10 irq enabled", irq, 1'b1);
        wr(4'd11, 8'h02); chk("R10 other clear", irq, 1'b1);
        wr(4'd11, 8'h01); chk("R10 w1c irq", irq, 1'b0);
        rd(4'd11, d); chk("R10 flag cleared", d, 8'h00);
        settle(8'h00);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_dir_alias();
        t_out_alias();
        t_cfg_mask();
        t_wired();
        t_input();
        t_edges();
        t_low();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule